// File: doc/BRIEF.md
# Round-Robin Measurement Sequencer

This block paces a hardware monitor's acquisition loop. It visits eleven measurement channels in a fixed order: the temperature sensor first, then seven voltage inputs, then three fan tachometers. For each channel it asks an external converter for one 8-bit result, with 16 mV per LSB and a 4.08 V full scale. It writes that result into a small value RAM at the address equal to the channel's position in the loop. After the last channel it waits out the rest of a pacing period before it starts the next pass. The default period is one second at 50 MHz.

The converter and the fan tach counters sit outside the block. They are reached through a request/done handshake that carries 8-bit data. A 2-bit kind code tells the outside logic which kind of source to route. The host reads results through a single read port. Any host read restarts the conversion in progress, so a done pulse that belongs to a cancelled request never reaches the RAM. Monitoring runs only while the start control is high and the interrupt-clear control is low. Otherwise the sequencer sits idle.

Top module: `mon_round_robin`

## Requirements
- R1: While reset is high and in the first cycle after it, conv_req, conv_abort and host_rd_valid are all low.
- R2: Requests follow channel codes 0,1,...,10 and then wrap to 0. Codes 0 to 10 stand for temperature, voltage inputs 0 to 4, the negative inputs 5 and 6, then fans 1 to 3. The result committed for code k is what a later host read of address k returns.
- R3: conv_kind is 0 (temperature) for code 0, 1 (voltage) for codes 1 to 7, and 2 (fan) for codes 8 to 10.
- R4: conv_req is a one-cycle pulse. No new first-time request is issued while a conversion is outstanding. A new request comes only after a done is accepted or as a restart.
- R5: Suppose a pass finishes before PERIOD_CYCLES cycles have passed since its first channel-0 request. Then the next pass's channel-0 request comes exactly PERIOD_CYCLES cycles after the previous one.
- R6: In the cycle after any cycle where cfg_start is low or cfg_int_clear is high, conv_req is low, and no result is committed during such a cycle.
- R7: After monitoring stops and then resumes, the first request is for code 0, whatever channel was in progress.
- R8: A host read in a cycle where a conversion is requested or outstanding makes conv_req and conv_abort both high in the next cycle, with the same conv_chan.
- R9: A done pulse in the same cycle as a host read, or one for a cancelled request, leaves the value RAM unchanged.
- R10: A host read gives host_rd_valid exactly one cycle later, with the most recently committed value of that address. Addresses 11 to 15 read as 0.
- R11: If monitoring stops while a conversion is requested or outstanding, conv_abort is high and conv_req is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Run control, high to monitor |
| cfg_int_clear | input | 1 | Interrupt-clear control, high holds the loop idle |
| conv_req | output | 1 | One-cycle request for a conversion of conv_chan |
| conv_abort | output | 1 | Cancels the outstanding conversion |
| conv_chan | output | 4 | Channel code, equal to its value RAM address |
| conv_kind | output | 2 | Source kind: 0 temperature, 1 voltage, 2 fan |
| conv_done | input | 1 | Conversion complete, data valid |
| conv_data | input | 8 | Conversion result |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_addr | input | 4 | Host read address |
| host_rd_data | output | 8 | Read data |
| host_rd_valid | output | 1 | Read data valid |

## Verification
The bench keeps the default channel split of seven voltage inputs and three fans, so the full fixed order and its wrap are covered. It shortens PERIOD_CYCLES to 200 so that a few thousand cycles hold a dozen paced passes, which makes the exact pass spacing checkable many times. The converter model draws a latency of 0 to 6 cycles for each request. That places random host reads in the request cycle, in the wait, and in the same cycle as a done. It also lets stops land in the middle of a pass.

// File: rtl/mon_rr_pkg.sv
package mon_rr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_PACE  = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    KIND_TEMP = 2'd0,
    KIND_VOLT = 2'd1,
    KIND_FAN  = 2'd2
  } meas_kind_t;

  // Position 0 is the temperature sensor, then n_volt voltage inputs, then fans.
  function automatic meas_kind_t kind_of(input int unsigned idx, input int unsigned n_volt);
    if (idx == 0) return KIND_TEMP;
    else if (idx <= n_volt) return KIND_VOLT;
    else return KIND_FAN;
  endfunction

endpackage

// File: rtl/mon_pace_timer.sv
module mon_pace_timer #(
  parameter int unsigned PERIOD_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic elapsed
);
  localparam int unsigned CNT_W = $clog2(PERIOD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  // Saturating count of cycles since the current pass began.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (cnt_q < LAST) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign elapsed = (cnt_q >= LAST);

  // R5: a fresh pass never sees the period as already over
  p_clear_restarts_r5: assert property (@(posedge clk) disable iff (rst)
    clear |=> !elapsed);

  // R5: once elapsed, the timer holds until the next pass begins
  p_elapsed_holds_r5: assert property (@(posedge clk) disable iff (rst)
    elapsed && !clear |=> elapsed);

endmodule

// File: rtl/mon_seq_ctrl.sv
module mon_seq_ctrl
  import mon_rr_pkg::*;
#(
  parameter int unsigned N_VOLT = 7,
  parameter int unsigned N_FAN  = 3,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NUM_CH = 1 + N_VOLT + N_FAN,
  localparam int unsigned ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              host_rd,
  input  logic              pace_elapsed,
  output logic              pace_clear,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_req,
  output logic              conv_abort,
  output logic [ADDR_W-1:0] conv_chan,
  output logic [1:0]        conv_kind,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int unsigned TAB_N = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_CH = ADDR_W'(NUM_CH - 1);

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] chan_q, chan_d;
  logic              req_q, abort_q;
  meas_kind_t        kind_q;
  meas_kind_t        kind_tab [TAB_N];
  logic              converting, accept, last_chan;

  // Kind lookup, one entry per code
  for (genvar g = 0; g < TAB_N; g++) begin : g_kind
    assign kind_tab[g] = kind_of(g, N_VOLT);
  end

  assign converting = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
  assign last_chan  = (chan_q == LAST_CH);
  // A done commits only in the wait state, while running, and with no read that cycle.
  assign accept     = run && !host_rd && (state_q == ST_WAIT) && conv_done;

  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    if (!run) begin
      state_d = ST_IDLE;
      chan_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_ISSUE;
        ST_ISSUE: state_d = host_rd ? ST_ISSUE : ST_WAIT;
        ST_WAIT: begin
          if (host_rd) begin
            state_d = ST_ISSUE;
          end else if (conv_done) begin
            if (last_chan) begin
              state_d = ST_PACE;
              chan_d  = '0;
            end else begin
              state_d = ST_ISSUE;
              chan_d  = chan_q + ADDR_W'(1);
            end
          end
        end
        ST_PACE:  if (pace_elapsed) state_d = ST_ISSUE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  assign pace_clear = run && ((state_q == ST_IDLE) || (state_q == ST_PACE))
                      && (state_d == ST_ISSUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      req_q   <= 1'b0;
      abort_q <= 1'b0;
      kind_q  <= KIND_TEMP;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      req_q   <= (state_d == ST_ISSUE);
      abort_q <= converting && (!run || host_rd);
      kind_q  <= kind_tab[chan_d];
    end
  end

  assign conv_req   = req_q;
  assign conv_abort = abort_q;
  assign conv_chan  = chan_q;
  assign conv_kind  = kind_q;
  assign wr_en      = accept;
  assign wr_addr    = chan_q;
  assign wr_data    = conv_data;

  // R4: a request lasts one cycle unless a read restarts it
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    conv_req && run && !host_rd |=> !conv_req);

  // R6: stopped means no request on the following cycle
  p_stop_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> !conv_req && (state_q == ST_IDLE));

  // R8: a read during a conversion reissues the same channel with an abort
  p_read_restart_r8: assert property (@(posedge clk) disable iff (rst)
    converting && run && host_rd |=> conv_req && conv_abort && $stable(chan_q));

  // R11: stopping mid-conversion cancels it
  p_stop_abort_r11: assert property (@(posedge clk) disable iff (rst)
    converting && !run |=> conv_abort && !conv_req);

  // R2: an accepted result moves the loop to the next channel in order
  p_next_chan_r2: assert property (@(posedge clk) disable iff (rst)
    accept && !last_chan |=> chan_q == $past(chan_q) + ADDR_W'(1));

  // R2: the channel code never leaves the live range
  p_chan_range_r2: assert property (@(posedge clk) disable iff (rst)
    chan_q <= LAST_CH);

endmodule

// File: rtl/mon_value_ram.sv
module mon_value_ram #(
  parameter int unsigned LIVE   = 11,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_raw_q;
  logic              in_range_q;
  logic              valid_q;

  // Plain synchronous write and registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_raw_q   <= mem[rd_addr];
      in_range_q <= (32'(rd_addr) < LIVE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= rd_en;
  end

  assign rd_data  = in_range_q ? rd_raw_q : '0;
  assign rd_valid = valid_q;

  // R10: every read strobe gives exactly one valid cycle, one cycle later
  p_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

endmodule

// File: rtl/mon_round_robin.sv
module mon_round_robin #(
  parameter int unsigned N_VOLT        = 7,
  parameter int unsigned N_FAN         = 3,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned PERIOD_CYCLES = 50_000_000,
  localparam int unsigned NUM_CH = 1 + N_VOLT + N_FAN,
  localparam int unsigned ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_start,
  input  logic              cfg_int_clear,
  output logic              conv_req,
  output logic              conv_abort,
  output logic [ADDR_W-1:0] conv_chan,
  output logic [1:0]        conv_kind,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_rd_addr,
  output logic [DATA_W-1:0] host_rd_data,
  output logic              host_rd_valid
);
  logic              run;
  logic              pace_clear, pace_elapsed;
  logic              ram_wr_en;
  logic [ADDR_W-1:0] ram_wr_addr;
  logic [DATA_W-1:0] ram_wr_data;

  assign run = cfg_start && !cfg_int_clear;

  mon_pace_timer #(
    .PERIOD_CYCLES(PERIOD_CYCLES)
  ) u_pace (
    .clk    (clk),
    .rst    (rst),
    .clear  (pace_clear),
    .elapsed(pace_elapsed)
  );

  mon_seq_ctrl #(
    .N_VOLT(N_VOLT),
    .N_FAN (N_FAN),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .host_rd     (host_rd_en),
    .pace_elapsed(pace_elapsed),
    .pace_clear  (pace_clear),
    .conv_done   (conv_done),
    .conv_data   (conv_data),
    .conv_req    (conv_req),
    .conv_abort  (conv_abort),
    .conv_chan   (conv_chan),
    .conv_kind   (conv_kind),
    .wr_en       (ram_wr_en),
    .wr_addr     (ram_wr_addr),
    .wr_data     (ram_wr_data)
  );

  mon_value_ram #(
    .LIVE  (NUM_CH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ram_wr_en),
    .wr_addr (ram_wr_addr),
    .wr_data (ram_wr_data),
    .rd_en   (host_rd_en),
    .rd_addr (host_rd_addr),
    .rd_data (host_rd_data),
    .rd_valid(host_rd_valid)
  );

  // R9: the cycle that carries an abort never commits a result
  p_abort_no_commit_r9: assert property (@(posedge clk) disable iff (rst)
    conv_abort |-> !ram_wr_en);

  // R3: fan codes are flagged as fan sources
  p_fan_kind_r3: assert property (@(posedge clk) disable iff (rst)
    conv_req && (32'(conv_chan) >= NUM_CH - N_FAN) |-> conv_kind == 2'd2);

endmodule

// File: tb/mon_round_robin_tb.sv
module mon_round_robin_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 200;
  localparam int NCH        = 11;
  localparam int AW         = 4;

  logic          clk = 1'b0, rst = 1'b1;
  logic          cfg_start = 1'b0, cfg_int_clear = 1'b0;
  logic          conv_done = 1'b0;
  logic [7:0]    conv_data = 8'h00;
  logic          host_rd_en = 1'b0;
  logic [AW-1:0] host_rd_addr = '0;
  logic          conv_req, conv_abort, host_rd_valid;
  logic [AW-1:0] conv_chan;
  logic [1:0]    conv_kind;
  logic [7:0]    host_rd_data;

  int n_checks = 0, n_errors = 0, cyc = 0;

  mon_round_robin #(.PERIOD_CYCLES(PERIOD)) u_dut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_int_clear(cfg_int_clear),
    .conv_req(conv_req), .conv_abort(conv_abort), .conv_chan(conv_chan),
    .conv_kind(conv_kind), .conv_done(conv_done), .conv_data(conv_data),
    .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr),
    .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int kind_exp(input int ch);
    if (ch == 0) return 0;
    if (ch <= 7) return 1;
    return 2;
  endfunction

  // Converter model: restarts on every request, drops work on abort.
  bit m_pend = 0; int m_cd = 0; int m_chan = 0; int lat_max = 6;
  always begin
    @(posedge clk); #1;
    conv_done = 1'b0;
    if (rst) m_pend = 0;
    else if (conv_req) begin
      m_pend = 1; m_cd = $urandom_range(0, lat_max); m_chan = int'(conv_chan);
    end else if (conv_abort) m_pend = 0;
    else if (m_pend) begin
      if (m_cd == 0) begin
        conv_done = 1'b1; conv_data = 8'($urandom); m_pend = 0;
      end else m_cd--;
    end
  end

  // Reference monitor, evaluated mid-cycle.
  bit [7:0] mirror [NCH];
  bit       known  [NCH];
  int exp_chan = 0, pend_chan = 0, restart_chan = 0, last_pass = 0;
  int rd_exp = 0, rd_addr_q = 0;
  bit busy = 0, exp_restart = 0, exp_stop_abort = 0, prev_run = 0;
  bit after_stop = 0, pass_valid = 0, rd_pend = 0, rd_known = 0, run_now = 0;
  int discard_hits = 0;

  always @(negedge clk) begin
    if (!rst) begin
      run_now = cfg_start && !cfg_int_clear;
      if (rd_pend) begin
        check(host_rd_valid, "R10", "read valid", int'(host_rd_valid), 1);
        if (rd_known)
          check(host_rd_data == 8'(rd_exp), (rd_addr_q < NCH) ? "R2/R9" : "R10",
                "read data", int'(host_rd_data), rd_exp);
      end else if (host_rd_valid) begin
        check(1'b0, "R10", "spurious valid", 1, 0);
      end
      if (exp_restart)
        check(conv_req && conv_abort && int'(conv_chan) == restart_chan, "R8",
              "restart chan", conv_req ? int'(conv_chan) : -1, restart_chan);
      if (exp_stop_abort)
        check(conv_abort && !conv_req, "R11", "stop abort", int'(conv_abort), 1);
      if (!prev_run)
        check(!conv_req, "R6", "request while stopped", int'(conv_req), 0);
      if (conv_req) begin
        if (!exp_restart) begin
          check(!busy, "R4", "request while outstanding", int'(busy), 0);
          check(int'(conv_chan) == exp_chan, "R2", "channel order", int'(conv_chan), exp_chan);
          if (after_stop) check(conv_chan == 0, "R7", "resume channel", int'(conv_chan), 0);
          after_stop = 0;
          if (conv_chan == 0) begin
            if (pass_valid)
              check(cyc - last_pass == PERIOD, "R5", "pass spacing", cyc - last_pass, PERIOD);
            last_pass = cyc; pass_valid = 1;
          end
        end
        check(int'(conv_kind) == kind_exp(int'(conv_chan)), "R3", "kind",
              int'(conv_kind), kind_exp(int'(conv_chan)));
        busy = 1; pend_chan = int'(conv_chan);
      end
      if (conv_done && host_rd_en) discard_hits++;
      exp_restart    = run_now && busy && host_rd_en;
      restart_chan   = pend_chan;
      exp_stop_abort = !run_now && busy;
      if (run_now && busy && !host_rd_en && conv_done && !conv_req) begin
        mirror[pend_chan] = conv_data; known[pend_chan] = 1; busy = 0;
        exp_chan = (pend_chan == NCH - 1) ? 0 : pend_chan + 1;
      end
      if (!run_now) begin
        busy = 0; exp_chan = 0; pass_valid = 0;
        if (prev_run) after_stop = 1;
      end
      rd_pend = host_rd_en;
      if (host_rd_en) begin
        rd_addr_q = int'(host_rd_addr);
        rd_known  = (rd_addr_q >= NCH) || known[rd_addr_q];
        rd_exp    = (rd_addr_q >= NCH) ? 0 : int'(mirror[rd_addr_q]);
      end
      prev_run = run_now;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      host_rd_en   = ($urandom_range(0, 15) == 0);
      host_rd_addr = AW'($urandom_range(0, 15));
    end
    tick(); host_rd_en = 1'b0;
  endtask

  task automatic stop_at(input int ch, input bit use_clear);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (conv_req && !conv_abort && int'(conv_chan) == ch) break;
    end
    tick();
    if (use_clear) cfg_int_clear = 1'b1; else cfg_start = 1'b0;
    for (int a = 0; a < NCH; a++) begin
      tick(); host_rd_en = 1'b1; host_rd_addr = AW'(a);
    end
    tick(); host_rd_en = 1'b0;
    repeat (3) tick();
    cfg_start = 1'b1; cfg_int_clear = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0B17));
    repeat (4) tick();
    @(negedge clk);
    check(!conv_req && !conv_abort && !host_rd_valid, "R1", "reset outputs",
          int'(conv_req) + int'(conv_abort) + int'(host_rd_valid), 0);
    tick(); rst = 1'b0;
    @(negedge clk);
    check(!conv_req && !conv_abort && !host_rd_valid, "R1", "post-reset outputs",
          int'(conv_req) + int'(conv_abort) + int'(host_rd_valid), 0);
    repeat (20) tick();
    cfg_start = 1'b1; cfg_int_clear = 1'b1;
    repeat (20) tick();
    cfg_int_clear = 1'b0;
    random_run(1500);
    // Directed: a read lands in the same cycle as a done (R9).
    lat_max = 3;
    for (int i = 0; i < 600 && discard_hits == 0; i++) begin
      @(negedge clk);
      if (m_pend && m_cd == 0 && !conv_req && known[m_chan]) begin
        tick(); host_rd_en = 1'b1; host_rd_addr = AW'(m_chan);
        tick(); host_rd_en = 1'b0;
        tick(); host_rd_en = 1'b1;
        tick(); host_rd_en = 1'b0;
      end
    end
    check(discard_hits > 0, "R9", "read/done collision reached", discard_hits, 1);
    lat_max = 6;
    stop_at(5, 1'b0);
    random_run(500);
    stop_at(9, 1'b1);
    random_run(600);
    stop_at(0, 1'b0);
    repeat (5) tick();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule